// File: doc/BRIEF.md
# Reversible-stage Gray code counter

This block is a synchronous counter whose output moves through every code of its width while changing exactly one bit per enabled clock, and it keeps doing so across the wrap back to zero. Its output drives the select lines of a wide readback multiplexer that sits outside the block. Because only one select bit moves per step, the multiplexer output never passes through an unrelated input on the way. The output is taken directly from the code flip-flops, so no decode gate sits between the state and the pins.

The counter is a chain of small stages. Each stage holds two code bits and a direction flag, except the last, which holds one or two bits depending on whether the width is odd or even. A stage walks its four codes forward or backward. When it reaches the end of its walk, it holds its value and reverses its direction flag, and the stage above it takes one step. When every stage sits at its end point, the whole chain returns to code zero with all stages facing forward. The resulting sequence is the binary-reflected Gray code of the number of enabled steps. Speed is not a goal, and the carry between stages is a plain AND chain.

Top module: `gray_ripple_counter`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `code` becomes 0 at that edge and every stage faces forward. The first enabled step after reset therefore produces code 1.
- R2: When `en` is low and `rst` is low, `code` keeps its value across the clock edge.
- R3: Each enabled clock changes exactly one bit of `code`. This includes the step from the last code back to 0.
- R4: Starting from 0, 2^WIDTH consecutive enabled steps visit every code exactly once and end on code 0.
- R5: Stage 0 (bits [1:0]) steps 00, 01, 11, 10 when facing forward and 10, 11, 01, 00 when facing backward. Its end points are 10 when forward and 00 when backward.
- R6: Any bit above bits [1:0] changes only on an enabled step in which bits [1:0] sit at their current end point. On such a step, bits [1:0] hold their value.
- R7: A stage faces backward exactly when the XOR of all code bits above that stage is 1. As a result, after n enabled steps since reset, `code` equals n XOR (n >> 1), taken modulo 2^WIDTH.
- R8: The last code of a cycle has only its most significant bit set. The next enabled step returns `code` to 0.
- R9: For an odd WIDTH, the top stage is a single bit, and R3, R4 and R7 hold at that width as well.
- R10: A reset that arrives in the middle of a run, with `en` also high, takes precedence. It gives code 0, and the next enabled step gives code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; when low, the code holds |
| code | output | WIDTH | Gray code output, taken directly from the flip-flops |

## Verification
The bench builds two instances: one at the default WIDTH of 6, which gives three full two-bit stages, and one at WIDTH 5, where the top stage shrinks to a single bit. The even instance brings the 64-step cover, the reversal of every middle stage, and the 100000-to-0 wrap within reach. The odd instance exercises the one-bit final stage and its 32-code wrap. A random mix of enable and occasional reset then drives both instances through partial cycles, through long holds, and through resets that arrive in the middle of a stage walk.

// File: rtl/gray_pkg.sv
package gray_pkg;

   // number of stages needed for a given output width
   function automatic int stage_count(input int width);
      return (width + 1) / 2;
   endfunction

   // width of the topmost stage: 2 for even widths, 1 for odd
   function automatic int last_width(input int width);
      return width - 2 * (((width + 1) / 2) - 1);
   endfunction

   // one step of a two-bit reversible stage
   function automatic logic [1:0] step2(input logic [1:0] cur, input logic rev);
      if (rev)
         return {~cur[0], cur[1]};
      else
         return {cur[0], ~cur[1]};
   endfunction

   // end point of a two-bit stage for its current direction
   function automatic logic [1:0] end2(input logic rev);
      return rev ? 2'b00 : 2'b10;
   endfunction

endpackage

// File: rtl/gray_stage.sv
module gray_stage
   import gray_pkg::*;
#(
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          act,
   input  logic          wrap,
   output logic [SW-1:0] code_o,
   output logic          at_end_o,
   output logic          rev_o
);

   logic [SW-1:0] code_q;
   logic [SW-1:0] code_nx;
   logic          rev_q;
   logic          at_end;

   generate
      if (SW != 1 && SW != 2) begin : g_bad_sw
         $error("gray_stage: SW must be 1 or 2");
      end

      if (SW == 2) begin : g_two
         always_comb begin
            code_nx = step2(code_q, rev_q);
            at_end  = (code_q == end2(rev_q));
         end
      end else begin : g_one
         always_comb begin
            code_nx = ~code_q;
            at_end  = (code_q == {SW{~rev_q}});
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || wrap) begin
         code_q <= '0;
         rev_q  <= 1'b0;
      end else if (act) begin
         if (at_end)
            rev_q <= ~rev_q;
         else
            code_q <= code_nx;
      end
   end

   assign code_o   = code_q;
   assign at_end_o = at_end;
   assign rev_o    = rev_q;

endmodule

// File: rtl/gray_end_chain.sv
module gray_end_chain #(
   parameter int N = 3
) (
   input  logic         en,
   input  logic [N-1:0] at_end,
   output logic [N-1:0] act,
   output logic         wrap
);

   generate
      if (N < 1) begin : g_bad_n
         $error("gray_end_chain: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_link
         if (i == 0) begin : g_first
            assign act[i] = en;
         end else begin : g_next
            assign act[i] = act[i-1] & at_end[i-1];
         end
      end
   endgenerate

   assign wrap = act[N-1] & at_end[N-1];

endmodule

// File: rtl/gray_ripple_counter.sv
module gray_ripple_counter
   import gray_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] code
);

   localparam int NSTG   = stage_count(WIDTH);
   localparam int LAST_W = last_width(WIDTH);

   logic [NSTG-1:0] at_end;
   logic [NSTG-1:0] act;
   logic [NSTG-1:0] stage_rev;
   logic            wrap;

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("gray_ripple_counter: WIDTH must lie in 2..32");
      end

      for (genvar i = 0; i < NSTG; i++) begin : g_stage
         localparam int SW = (i == NSTG - 1) ? LAST_W : 2;
         gray_stage #(.SW(SW)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .act      (act[i]),
            .wrap     (wrap),
            .code_o   (code[2*i +: SW]),
            .at_end_o (at_end[i]),
            .rev_o    (stage_rev[i])
         );
      end
   endgenerate

   gray_end_chain #(.N(NSTG)) u_chain (
      .en     (en),
      .at_end (at_end),
      .act    (act),
      .wrap   (wrap)
   );

endmodule

// File: rtl/gray_counter_checker.sv
module gray_counter_checker
   import gray_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           en,
   input logic [WIDTH-1:0]               code,
   input logic [stage_count(WIDTH)-1:0]  stage_rev
);

   localparam int NSTG = stage_count(WIDTH);

   logic low_par;
   logic low_at_end;

   always_comb begin
      low_par    = ^(code >> 2);
      low_at_end = (code[1:0] == end2(low_par));
   end

   AST_RESET_TO_ZERO: assert property (@(posedge clk)
      rst |=> (code == '0)); // R1

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(code)); // R2

   AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
      en |=> ($countones(code ^ $past(code)) == 1)); // R3

   AST_LOW_STAGE_FIRST: assert property (@(posedge clk) disable iff (rst)
      (en && !low_at_end) |=> $stable(code >> 2)); // R6

   AST_LOW_HOLD_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
      (en && low_at_end) |=> $stable(code[1:0])); // R6

   generate
      for (genvar i = 0; i < NSTG; i++) begin : g_dir
         localparam int SH = 2 * i + 2;
         AST_DIR_FOLLOWS_PARITY: assert property (@(posedge clk) disable iff (rst)
            en |=> (stage_rev[i] == (^(code >> SH)))); // R7
      end
   endgenerate

endmodule

bind gray_ripple_counter gray_counter_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .code      (code),
   .stage_rev (stage_rev)
);

// File: tb/tb_gray_ripple_counter.sv
module tb_gray_ripple_counter;

   localparam int CLK_PERIOD = 10;
   localparam int W_EVEN     = 6;
   localparam int W_ODD      = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [W_EVEN-1:0] code6;
   logic [W_ODD-1:0]  code5;

   int tests = 0;
   int fails = 0;
   int n6 = 0;
   int n5 = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gray_ripple_counter #(.WIDTH(W_EVEN)) dut (
      .clk(clk), .rst(rst), .en(en), .code(code6));

   gray_ripple_counter #(.WIDTH(W_ODD)) dut_odd (
      .clk(clk), .rst(rst), .en(en), .code(code5));

   function automatic int gray_of(input int n);
      return n ^ (n >> 1);
   endfunction

   function automatic int ones(input int v);
      int c = 0;
      for (int b = 0; b < 32; b++) c += (v >> b) & 1;
      return c;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic tick(input logic r, input logic e);
      logic [W_EVEN-1:0] p6;
      logic [W_ODD-1:0]  p5;
      p6 = code6;
      p5 = code5;
      rst = r;
      en  = e;
      @(negedge clk);
      if (r) begin
         n6 = 0;
         n5 = 0;
      end else if (e) begin
         n6 = (n6 + 1) % (1 << W_EVEN);
         n5 = (n5 + 1) % (1 << W_ODD);
      end
      chk("R7 even sequence", int'(code6), gray_of(n6));
      chk("R9 odd sequence", int'(code5), gray_of(n5));
      if (!r && e) begin
         chk("R3 one bit even", ones(int'(code6 ^ p6)), 1);
         chk("R3 one bit odd", ones(int'(code5 ^ p5)), 1);
         if (code6[5:2] != p6[5:2])
            chk("R6 low holds on carry", int'(code6[1:0]), int'(p6[1:0]));
      end
      if (!r && !e) begin
         chk("R2 hold even", int'(code6), int'(p6));
         chk("R2 hold odd", int'(code5), int'(p5));
      end
   endtask

   initial begin
      logic [63:0] seen;
      logic [31:0] seen5;
      int pos;
      void'($urandom(32'd20240611));
      @(negedge clk);

      // reset
      tick(1, 0);
      tick(1, 0);
      chk("R1 reset even", int'(code6), 0);
      chk("R1 reset odd", int'(code5), 0);

      // idle hold
      for (int k = 0; k < 5; k++) tick(0, 0);
      chk("R2 idle after reset", int'(code6), 0);

      // first step after reset
      tick(0, 1);
      chk("R1 first step", int'(code6), 1);
      tick(1, 0);

      // full even cycle with cover, low-stage order and wrap
      seen  = '0;
      seen5 = '0;
      seen[0]  = 1'b1;
      seen5[0] = 1'b1;
      for (int k = 1; k <= 64; k++) begin
         if (k == 64) chk("R8 last code", int'(code6), 32);
         if (k == 32) chk("R8 odd last code", int'(code5), 16);
         tick(0, 1);
         pos = ((k / 4) % 2 == 0) ? (k % 4) : (3 - (k % 4));
         chk("R5 low stage order", int'(code6[1:0]), (pos == 0) ? 0 : (pos == 1) ? 1 : (pos == 2) ? 3 : 2);
         if (k < 64) begin
            chk("R4 no repeat", int'(seen[code6]), 0);
            seen[code6] = 1'b1;
         end
         if (k < 32) begin
            chk("R9 odd no repeat", int'(seen5[code5]), 0);
            seen5[code5] = 1'b1;
         end
         if (k == 32) chk("R9 odd wrap", int'(code5), 0);
      end
      chk("R4 full cover", int'(&seen), 1);
      chk("R9 odd full cover", int'(&seen5), 1);
      chk("R8 wrap to zero", int'(code6), 0);

      // mid-run reset with enable high
      for (int k = 0; k < 10; k++) tick(0, 1);
      tick(1, 1);
      chk("R10 mid reset", int'(code6), 0);
      chk("R10 mid reset odd", int'(code5), 0);
      tick(0, 1);
      chk("R10 step after reset", int'(code6), 1);

      // random enable with rare reset
      for (int k = 0; k < 3000; k++) begin
         logic r;
         logic e;
         r = (($urandom % 97) == 0);
         e = (($urandom % 4) != 0);
         tick(r, e);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog R3: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule